// File: doc/BRIEF.md
# Error-Sequence Front End for a Rate-3/4 Trellis Decoder

This block sits in front of a trellis decoder for a rate-3/4 systematic convolutional code. Each accepted received word carries four soft symbols. The block slices them to hard bits and takes the three information positions as a tentative information word. It then rebuilds the parity bit from that word with its own encoder memory. Each received symbol is XORed with the matching re-encoded bit, which gives the error word handed to the decoder. When the channel is clean, the error stream is all zero, so the decoder behind it stays in its zero state almost all the time.

The tentative information words also travel through a delay line whose depth equals the decoder search length. That depth is six times the constraint length. When a word is accepted, the decoder's 3-bit estimate of the information error is XORed with the word leaving the delay line. The result is the final information word. The error word and the final information word are both registered and presented together under a valid/ready handshake.

Top module: `err_seq_front_end`

## Requirements
- R1: A synchronous active-high reset clears the encoder memory and the delay line to zero. It also clears out_valid, err_word and info_word to zero.
- R2: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, err_word and info_word hold their values.
- R3: Symbol j of rx_word occupies bits [j*QBITS+QBITS-1 : j*QBITS], and its hard bit is the MSB (natural binary levels; levels at or above the midpoint read as 1). Symbol 0 is the parity position. Symbols 1, 2 and 3 carry information bits x1, x2 and x3, so the tentative word is u = {hard3, hard2, hard1}. The re-encoded parity is p = x1(t)^x1(t-1) ^ x2(t)^x2(t-2) ^ x3(t)^x3(t-1)^x3(t-2), taken over accepted words only. The hard bit of error symbol 0 equals hard0 XOR p.
- R4: The hard bits of error symbols 1, 2 and 3 are always zero.
- R5: Every bit of error symbol j equals the corresponding bit of received symbol j XOR the re-encoded bit of that position. The re-encoded bits are p for symbol 0 and x1, x2, x3 for symbols 1 to 3.
- R6: A stream of error-free code words at the extreme levels (all ones or all zeros per symbol) yields an all-zero err_word.
- R7: info_word = dec_est XOR the tentative word accepted 6*CONSTR_LEN accepted words earlier. Bit i of info_word is x(i+1). The delayed word reads as zero until that many words have been accepted since reset.
- R8: Cycles without an accepted word leave the encoder memory, the delay line, err_word and info_word unchanged.
- R9: The outputs for an accepted word appear in the cycle after acceptance with out_valid high. out_valid falls one cycle after out_ready is high with no new word accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| rx_word | input | 4*QBITS | Four quantised received symbols |
| dec_est | input | 3 | Decoder's information-error estimate, sampled on acceptance |
| out_valid | output | 1 | err_word and info_word are valid |
| out_ready | input | 1 | Downstream takes the outputs |
| err_word | output | 4*QBITS | Received error word for the decoder |
| info_word | output | 3 | Final information estimate |

## Verification
One acceptance does two things at once: it forms the error word for the newest received word, and it releases the corrected information word for the word accepted one search length earlier. The bench streams more than 6*CONSTR_LEN words back to back with nonzero estimates, so every acceptance after the fill point exercises both paths. It checks both output fields against a model kept in the bench. It also stalls the output while a word is offered, and it resets in mid-stream. These two cases confirm that neither the encoder memory nor the delay line advances on a word that was not taken.

// File: rtl/err_seq_fe_pkg.sv
package err_seq_fe_pkg;

    localparam int NSYM  = 4;   // symbols per received word
    localparam int NINFO = 3;   // information bits per word

    typedef logic [NINFO-1:0] info_t;

    // encoder memory: word one step back and two steps back
    typedef struct packed {
        info_t d1;
        info_t d2;
    } enc_mem_t;

    // parity of (1+D) x1 + (1+D^2) x2 + (1+D+D^2) x3
    function automatic logic parity_of(info_t u, enc_mem_t m);
        return (u[0] ^ m.d1[0]) ^ (u[1] ^ m.d2[1]) ^ (u[2] ^ m.d1[2] ^ m.d2[2]);
    endfunction

    // code word: position 0 parity, positions 1..3 information bits
    function automatic logic [NSYM-1:0] code_of(info_t u, logic p);
        return {u, p};
    endfunction

    function automatic enc_mem_t mem_step(info_t u, enc_mem_t m);
        enc_mem_t n;
        n.d1 = u;
        n.d2 = m.d1;
        return n;
    endfunction

endpackage

// File: rtl/esf_slicer.sv
module esf_slicer
    import err_seq_fe_pkg::*;
#(
    parameter int QBITS = 3
) (
    input  logic [NSYM*QBITS-1:0] rx,
    output info_t                 u_hat,
    output logic                  par_hard
);
    logic [NSYM-1:0] hard;

    for (genvar j = 0; j < NSYM; j++) begin : g_msb
        assign hard[j] = rx[j*QBITS + QBITS - 1];
    end

    // right inverse of the systematic generator: pick the information positions
    assign u_hat    = hard[NSYM-1:1];
    assign par_hard = hard[0];
endmodule

// File: rtl/esf_reencoder.sv
module esf_reencoder
    import err_seq_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  info_t u,
    output logic  p
);
    enc_mem_t mem_q;

    assign p = parity_of(u, mem_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (adv) begin
            mem_q <= mem_step(u, mem_q);
        end
    end
endmodule

// File: rtl/esf_err_merge.sv
module esf_err_merge
    import err_seq_fe_pkg::*;
#(
    parameter int QBITS = 3
) (
    input  logic [NSYM*QBITS-1:0] rx,
    input  logic [NSYM-1:0]       v,
    output logic [NSYM*QBITS-1:0] err
);
    for (genvar j = 0; j < NSYM; j++) begin : g_sym
        assign err[j*QBITS +: QBITS] = rx[j*QBITS +: QBITS] ^ {QBITS{v[j]}};
    end
endmodule

// File: rtl/esf_delay_line.sv
module esf_delay_line
    import err_seq_fe_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  info_t din,
    output info_t tail
);
    info_t stage_q [DEPTH];

    assign tail = stage_q[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else if (adv) begin
            for (int i = DEPTH - 1; i > 0; i--) stage_q[i] <= stage_q[i-1];
            stage_q[0] <= din;
        end
    end
endmodule

// File: rtl/err_seq_front_end.sv
module err_seq_front_end
    import err_seq_fe_pkg::*;
#(
    parameter int QBITS      = 3,
    parameter int CONSTR_LEN = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NSYM*QBITS-1:0] rx_word,
    input  logic [NINFO-1:0]      dec_est,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [NSYM*QBITS-1:0] err_word,
    output logic [NINFO-1:0]      info_word
);
    localparam int DEPTH  = 6 * CONSTR_LEN;
    localparam int WORD_W = NSYM * QBITS;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] err;
        info_t             info;
    } out_rec_t;

    out_rec_t          out_q;
    info_t             u_hat;
    info_t             u_old;
    logic              par_hard;
    logic              p_hat;
    logic              accept;
    logic [NSYM-1:0]   v_word;
    logic [WORD_W-1:0] err_next;

    assign in_ready = !out_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    esf_slicer #(.QBITS(QBITS)) i_slicer (
        .rx       (rx_word),
        .u_hat    (u_hat),
        .par_hard (par_hard)
    );

    esf_reencoder i_reenc (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .u   (u_hat),
        .p   (p_hat)
    );

    assign v_word = code_of(u_hat, p_hat);

    esf_err_merge #(.QBITS(QBITS)) i_merge (
        .rx  (rx_word),
        .v   (v_word),
        .err (err_next)
    );

    esf_delay_line #(.DEPTH(DEPTH)) i_dly (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .din  (u_hat),
        .tail (u_old)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (accept) begin
            out_q.vld  <= 1'b1;
            out_q.err  <= err_next;
            out_q.info <= u_old ^ dec_est;
        end else if (out_ready) begin
            out_q.vld <= 1'b0;
        end
    end

    assign out_valid = out_q.vld;
    assign err_word  = out_q.err;
    assign info_word = out_q.info;

    logic unused_par;
    assign unused_par = par_hard;
endmodule

// File: rtl/esf_checker.sv
module esf_checker #(
    parameter int QBITS = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [4*QBITS-1:0] err_word,
    input logic [2:0]         info_word
);
    localparam int H1 = 2*QBITS - 1;
    localparam int H2 = 3*QBITS - 1;
    localparam int H3 = 4*QBITS - 1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && err_word == '0 && info_word == '0));

    assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(err_word) && $stable(info_word)));

    assert_data_hard_zero_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!err_word[H1] && !err_word[H2] && !err_word[H3]));

    assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(err_word) && $stable(info_word)));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && out_ready) |=> !out_valid);
endmodule

bind err_seq_front_end esf_checker #(.QBITS(QBITS)) i_esf_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .err_word  (err_word),
    .info_word (info_word)
);

// File: tb/test_err_seq_front_end.sv
module test_err_seq_front_end;
    localparam int Q     = 3;
    localparam int CL    = 2;
    localparam int DEPTH = 6 * CL;
    localparam int W     = 4 * Q;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] rx_word = '0;
    logic [2:0]   dec_est = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] err_word;
    logic [2:0]   info_word;

    always #10 clk = ~clk;   // 50 MHz

    err_seq_front_end #(.QBITS(Q), .CONSTR_LEN(CL)) i_err_seq_front_end (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .rx_word(rx_word), .dec_est(dec_est), .out_valid(out_valid),
        .out_ready(out_ready), .err_word(err_word), .info_word(info_word)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic [2:0] m1, m2;
    logic [2:0] hist [0:1023];
    int         cnt;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] next_rand(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic model_clear();
        m1 = '0; m2 = '0; cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // offer one word and check it one cycle after acceptance
    task automatic push(input logic [W-1:0] rx, input logic [2:0] est, input string tag);
        logic [2:0]   u;
        logic         p;
        logic [3:0]   v;
        logic [W-1:0] exp_err;
        logic [2:0]   exp_info;
        u = {rx[4*Q-1], rx[3*Q-1], rx[2*Q-1]};
        p = u[0] ^ m1[0] ^ u[1] ^ m2[1] ^ u[2] ^ m1[2] ^ m2[2];
        v = {u, p};
        for (int j = 0; j < 4; j++) exp_err[j*Q +: Q] = rx[j*Q +: Q] ^ {Q{v[j]}};
        exp_info = (cnt >= DEPTH) ? (est ^ hist[cnt - DEPTH]) : est;
        hist[cnt] = u; cnt++;
        m2 = m1; m1 = u;
        rx_word = rx; dec_est = est; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R9 out_valid after accept", W'(out_valid), W'(1));
        check(err_word === exp_err, tag, err_word, exp_err);
        check(info_word === exp_info, "R7 info_word", W'(info_word), W'(exp_info));
    endtask

    task automatic t_reset();
        check(out_valid === 1'b0, "R1 out_valid after reset", W'(out_valid), W'(0));
        check(err_word === '0, "R1 err_word after reset", err_word, '0);
        check(info_word === '0, "R1 info_word after reset", W'(info_word), W'(0));
        check(in_ready === 1'b1, "R2 in_ready when idle", W'(in_ready), W'(1));
    endtask

    // error-free code words at extreme levels: error stream is all zero
    task automatic t_clean_stream();
        logic [2:0] x, e1, e2;
        logic       p;
        logic [W-1:0] rx;
        e1 = '0; e2 = '0;
        for (int k = 0; k < 30; k++) begin
            lfsr = next_rand(lfsr);
            x = lfsr[2:0];
            p = x[0] ^ e1[0] ^ x[1] ^ e2[1] ^ x[2] ^ e1[2] ^ e2[2];
            e2 = e1; e1 = x;
            rx = {{Q{x[2]}}, {Q{x[1]}}, {Q{x[0]}}, {Q{p}}};
            push(rx, 3'b000, "R6 clean stream err_word");
            check(err_word === '0, "R6 zero error word", err_word, '0);
        end
    endtask

    // arbitrary soft words with estimates, crossing the delay depth
    task automatic t_soft_errors();
        for (int k = 0; k < 40; k++) begin
            lfsr = next_rand(lfsr);
            push(W'(lfsr), lfsr[15:13], "R3 R5 soft err_word");
            check(err_word[2*Q-1] === 1'b0 && err_word[3*Q-1] === 1'b0 && err_word[4*Q-1] === 1'b0,
                  "R4 data hard bits zero", err_word, err_word & ~W'({1'b1, {Q-1{1'b0}}, 1'b1, {Q-1{1'b0}}, 1'b1, {2*Q-1{1'b0}}}));
        end
    endtask

    // stall with a word offered, then idle cycles: nothing advances
    task automatic t_stall();
        logic [W-1:0] held_err;
        logic [2:0]   held_info;
        push(12'h5A3, 3'b011, "R3 pre-stall word");
        held_err = err_word; held_info = info_word;
        out_ready = 1'b0; in_valid = 1'b1; rx_word = 12'hFFF; dec_est = 3'b111;
        #1;
        check(in_ready === 1'b0, "R2 in_ready low while stalled", W'(in_ready), W'(0));
        repeat (3) @(negedge clk);
        check(err_word === held_err, "R2 R8 err held during stall", err_word, held_err);
        check(info_word === held_info, "R2 R8 info held during stall", W'(info_word), W'(held_info));
        push(12'h9C6, 3'b100, "R8 word after stall");
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 out_valid drops", W'(out_valid), W'(0));
        repeat (4) @(negedge clk);
        push(12'h36D, 3'b001, "R8 word after idle gap");
    endtask

    // mid-stream reset empties delay line and encoder memory
    task automatic t_reset_midstream();
        do_reset();
        t_reset();
        for (int k = 0; k < 2*DEPTH + 3; k++) begin
            lfsr = next_rand(lfsr);
            push(W'(lfsr), 3'b101 ^ lfsr[2:0], "R1 R3 word after reset");
        end
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean_stream();
        t_soft_errors();
        t_stall();
        t_reset_midstream();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule